// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block turns a programmed mode word and a column command into the column address of every beat of an SDRAM burst. A mode word chooses the burst length (2, 4 or 8 beats), the beat ordering, the read latency and whether writes follow the burst length or are cut to one beat. A command captures a start column. From the next cycle on, the block issues one beat address per clock. The low column bits follow either a wrapping count or an XOR pattern inside the aligned burst block. The bits above that block do not change.

For reads the block also produces the data window. `rd_valid` marks each beat at its latency slot. `dq_drive` goes high one cycle before the first valid beat and falls together with `rd_valid`. The sequencer is controlled by three states:
- `ST_IDLE`: nothing is issued.
- `ST_BURST`: beats are issued.
- `ST_DRAIN`: the last read beat has been issued, but its data slots have not all passed.

The transitions are:
- IDLE→BURST on a command.
- BURST→BURST on the next beat or on a new command.
- BURST→DRAIN after the last read beat.
- BURST→IDLE after the last write beat.
- DRAIN→IDLE when no read slot is still pending.
- DRAIN→BURST on a command.

Mode word fields:
- [2:0] length code: 1 = 2 beats, 2 = 4 beats, 3 = 8 beats.
- [3] order: 0 = wrapping, 1 = XOR.
- [6:4] latency: 2 or 3.
- [8:7] must be 0.
- [9] single-beat writes.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset the block is idle (`beat_vld`, `dq_drive`, `rd_valid` and `mode_err` low). The active setting after reset is 4 beats, wrapping order, latency 2, and writes that use the burst length.
- R2: A mode load whose length code is not 1–3, whose latency code is not 2 or 3, or whose bits [8:7] are not 0 sets `mode_err` on the next cycle and leaves every setting unchanged. A legal load applies the new settings and clears `mode_err`.
- R3: In wrapping order, the low bits of beat k are (start + k) mod BL. Example: for 8 beats starting at 5, the order is 5,6,7,0,1,2,3,4.
- R4: In XOR order, the low bits of beat k are start XOR k. Examples: for 8 beats from 5, the order is 5,4,7,6,1,0,3,2; for 4 beats from 3, it is 3,2,1,0.
- R5: Column bits at or above bit log2(BL) keep the value of the start column for the whole burst.
- R6: A command sampled at edge n makes `beat_vld` high from edge n to edge n+BL−1. Beat 0 carries the start column, and one beat follows on each clock.
- R7: For a read beat issued in the cycle after edge t, `rd_valid` is high in the cycle after edge t+CL. The latency CL is the setting at the time of the command.
- R8: `dq_drive` rises one cycle before the first `rd_valid` of a read. It stays high through the last `rd_valid` and falls in the same cycle as `rd_valid`.
- R9: A write issues BL beats when bit 9 was 0 and exactly one beat when bit 9 was 1. A write never raises `rd_valid` or `dq_drive`.
- R10: A command that arrives during a burst or its read window abandons the old burst and its pending data slots. The new burst starts on the next cycle.
- R11: After the last beat and its data slots, all three flags are low and stay low until the next command.
- R12: A command and a mode load in the same cycle: the command uses the settings that were active before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | Mode word write strobe |
| mode_word | input | 10 | Mode word |
| cmd_vld | input | 1 | Column command strobe |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| start_col | input | COL_W | Starting column of the burst |
| beat_col | output | COL_W | Column of the current beat |
| beat_vld | output | 1 | A beat column is being issued |
| dq_drive | output | 1 | Data drivers enabled for reads |
| rd_valid | output | 1 | Read data valid for a beat |
| mode_err | output | 1 | Last mode load was rejected |

## Verification
The bench builds the block with COL_W = 10, one bit wider than the default. The upper column bits therefore hold a pattern that the wrap and XOR logic must leave alone at all three burst lengths. Latencies 2 and 3 are both programmed, so the driver lead and data tail are exercised at each latency. Back-to-back commands cut across bursts and read tails.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    localparam int MODE_W   = 10;
    localparam int HIST_W   = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_t;

    typedef enum logic {
        ORD_WRAP = 1'b0,
        ORD_XOR  = 1'b1
    } order_t;

    typedef struct packed {
        logic [1:0] len_log;
        order_t     order;
        logic [1:0] lat;
        logic       wr_single;
    } mode_cfg_t;

    localparam mode_cfg_t CFG_RESET = '{len_log: 2'd2, order: ORD_WRAP,
                                        lat: 2'd2, wr_single: 1'b0};
endpackage

// File: rtl/sbs_mode_reg.sv
module sbs_mode_reg
    import sbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [MODE_W-1:0] word,
    output mode_cfg_t         cfg,
    output logic              err
);
    logic      len_ok;
    logic      lat_ok;
    logic      rsv_ok;
    mode_cfg_t decoded;

    always_comb begin
        len_ok            = (word[2:0] == 3'd1) || (word[2:0] == 3'd2) || (word[2:0] == 3'd3);
        lat_ok            = (word[6:4] == 3'd2) || (word[6:4] == 3'd3);
        rsv_ok            = (word[8:7] == 2'b00);
        decoded.len_log   = word[1:0];
        decoded.order     = order_t'(word[3]);
        decoded.lat       = word[5:4];
        decoded.wr_single = word[9];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
            err <= 1'b0;
        end else if (load) begin
            if (len_ok && lat_ok && rsv_ok) begin
                cfg <= decoded;
                err <= 1'b0;
            end else begin
                err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sbs_addr_gen.sv
module sbs_addr_gen
    import sbs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [2:0]       idx,
    input  logic [1:0]       len_log,
    input  order_t           order,
    output logic [COL_W-1:0] col
);
    logic [2:0] wrap_off;
    logic [2:0] xor_off;
    logic [2:0] pick;

    always_comb begin
        wrap_off = base[2:0] + idx;
        xor_off  = base[2:0] ^ idx;
        pick     = (order == ORD_XOR) ? xor_off : wrap_off;
    end

    for (genvar b = 0; b < 3; b++) begin : g_low
        assign col[b] = (2'(b) < len_log) ? pick[b] : base[b];
    end

    if (COL_W > 3) begin : g_high
        assign col[COL_W-1:3] = base[COL_W-1:3];
    end
endmodule

// File: rtl/sbs_rd_window.sv
module sbs_rd_window
    import sbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       push,
    input  logic [1:0] lat,
    output logic       rd_valid,
    output logic       dq_drive,
    output logic       pending
);
    logic [HIST_W-1:0] hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else if (flush) begin
            hist <= {{(HIST_W-1){1'b0}}, push};
        end else begin
            hist <= {hist[HIST_W-2:0], push};
        end
    end

    always_comb begin
        rd_valid = hist[lat];
        dq_drive = hist[lat] | hist[lat - 2'd1];
        pending  = 1'b0;
        for (int j = 0; j < HIST_W; j++) begin
            if (j < int'(lat)) pending = pending | hist[j];
        end
    end
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sbs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_load,
    input  logic [9:0]       mode_word,
    input  logic             cmd_vld,
    input  logic             cmd_rd,
    input  logic [COL_W-1:0] start_col,
    output logic [COL_W-1:0] beat_col,
    output logic             beat_vld,
    output logic             dq_drive,
    output logic             rd_valid,
    output logic             mode_err
);
    seq_state_t       state_q, state_n;
    mode_cfg_t        cfg;
    logic [COL_W-1:0] base_q;
    logic [2:0]       idx_q;
    logic [2:0]       last_q;
    logic [1:0]       len_q;
    order_t           ord_q;
    logic [1:0]       lat_q;
    logic             rd_q;
    logic             rd_n;
    logic             at_last;
    logic             tail;

    sbs_mode_reg u_mode (
        .clk  (clk),
        .rst  (rst),
        .load (mode_load),
        .word (mode_word),
        .cfg  (cfg),
        .err  (mode_err)
    );

    sbs_addr_gen #(.COL_W(COL_W)) u_addr (
        .base    (base_q),
        .idx     (idx_q),
        .len_log (len_q),
        .order   (ord_q),
        .col     (beat_col)
    );

    assign at_last = (idx_q == last_q);
    assign rd_n    = cmd_vld ? cmd_rd : rd_q;

    sbs_rd_window u_win (
        .clk      (clk),
        .rst      (rst),
        .flush    (cmd_vld),
        .push     ((state_n == ST_BURST) && rd_n),
        .lat      (lat_q),
        .rd_valid (rd_valid),
        .dq_drive (dq_drive),
        .pending  (tail)
    );

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  if (cmd_vld) state_n = ST_BURST;
            ST_BURST: begin
                if (cmd_vld)      state_n = ST_BURST;
                else if (at_last) state_n = rd_q ? ST_DRAIN : ST_IDLE;
                else              state_n = ST_BURST;
            end
            ST_DRAIN: begin
                if (cmd_vld)   state_n = ST_BURST;
                else if (!tail) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_n;
    end

    // output and burst-context registers
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            idx_q    <= '0;
            last_q   <= '0;
            len_q    <= CFG_RESET.len_log;
            ord_q    <= CFG_RESET.order;
            lat_q    <= CFG_RESET.lat;
            rd_q     <= 1'b0;
            beat_vld <= 1'b0;
        end else begin
            beat_vld <= (state_n == ST_BURST);
            if (cmd_vld) begin
                base_q <= start_col;
                idx_q  <= '0;
                len_q  <= cfg.len_log;
                ord_q  <= cfg.order;
                lat_q  <= cfg.lat;
                rd_q   <= cmd_rd;
                last_q <= (cmd_rd || !cfg.wr_single) ? ((3'd1 << cfg.len_log) - 3'd1) : 3'd0;
            end else if (state_q == ST_BURST && !at_last) begin
                idx_q <= idx_q + 3'd1;
            end
        end
    end
endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             mode_load,
    input logic [9:0]       mode_word,
    input logic             cmd_vld,
    input logic             cmd_rd,
    input logic [COL_W-1:0] start_col,
    input logic [COL_W-1:0] beat_col,
    input logic             beat_vld,
    input logic             dq_drive,
    input logic             rd_valid,
    input logic             mode_err
);
    p_first_beat_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_vld |=> (beat_vld && beat_col == $past(start_col)));

    p_drive_cover_r8: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> dq_drive);

    p_drive_lead_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> $past(dq_drive));

    p_rsv_reject_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_load && mode_word[8:7] != 2'b00) |=> mode_err);

    p_write_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && !cmd_rd) |=> !rd_valid);

    p_upper_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (beat_vld && $past(beat_vld) && !$past(cmd_vld))
            |-> (beat_col[COL_W-1:3] == $past(beat_col[COL_W-1:3])));
endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/sdram_burst_seq_tb.sv
module sdram_burst_seq_tb_top;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mode_load = 1'b0;
    logic [9:0]       mode_word = '0;
    logic             cmd_vld = 1'b0;
    logic             cmd_rd = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [COL_W-1:0] beat_col;
    logic             beat_vld;
    logic             dq_drive;
    logic             rd_valid;
    logic             mode_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    sdram_burst_seq #(.COL_W(COL_W)) dut_i (.*);

    // behavioural reference model
    int m_len = 2, m_ord = 0, m_cl = 2, m_ws = 0, m_err = 0;
    int a_start = 0, a_lbits = 2, a_len = 0, a_ord = 0, a_cl = 2, a_rd = 0, a_idx = -1;
    int hist [4] = '{0, 0, 0, 0};

    always @(posedge clk) begin
        if (rst) begin
            m_len = 2; m_ord = 0; m_cl = 2; m_ws = 0; m_err = 0;
            a_idx = -1; a_cl = 2; a_rd = 0;
            for (int k = 0; k < 4; k++) hist[k] = 0;
        end else begin
            if (cmd_vld) begin
                a_start = int'(start_col); a_lbits = m_len; a_ord = m_ord; a_cl = m_cl;
                a_rd = int'(cmd_rd);
                a_len = (cmd_rd || m_ws == 0) ? (1 << m_len) : 1;
                a_idx = 0;
                for (int k = 0; k < 4; k++) hist[k] = 0;
                hist[0] = a_rd;
            end else begin
                if (a_idx >= 0 && a_idx < a_len - 1) a_idx++;
                else a_idx = -1;
                for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
                hist[0] = (a_idx >= 0) ? a_rd : 0;
            end
            if (mode_load) begin
                int bl, cl;
                bl = int'(mode_word[2:0]);
                cl = int'(mode_word[6:4]);
                if (bl >= 1 && bl <= 3 && (cl == 2 || cl == 3) && mode_word[8:7] == 2'b00) begin
                    m_len = bl; m_ord = int'(mode_word[3]); m_cl = cl;
                    m_ws = int'(mode_word[9]); m_err = 0;
                end else begin
                    m_err = 1;
                end
            end
        end
    end

    function automatic int exp_col();
        int mask, off;
        mask = (1 << a_lbits) - 1;
        if (a_ord == 1) off = (a_start & mask) ^ a_idx;
        else            off = (a_start + a_idx) & mask;
        return (a_start & ~mask) | off;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            int ev;
            ev = (a_idx >= 0) ? 1 : 0;
            chk(int'(beat_vld) == ev, "R6/R9/R10/R11 beat_vld", int'(beat_vld), ev);
            if (ev == 1)
                chk(int'(beat_col) == exp_col(), a_ord == 1 ? "R4/R5 beat_col" : "R3/R5 beat_col",
                    int'(beat_col), exp_col());
            chk(int'(rd_valid) == hist[a_cl], "R7 rd_valid", int'(rd_valid), hist[a_cl]);
            ev = hist[a_cl] | hist[a_cl-1];
            chk(int'(dq_drive) == ev, "R8 dq_drive", int'(dq_drive), ev);
            chk(int'(mode_err) == m_err, "R2 mode_err", int'(mode_err), m_err);
        end
    end

    function automatic logic [9:0] mw(int bl, int ord, int cl, int ws, int rsv);
        return {ws[0], rsv[1:0], cl[2:0], ord[0], bl[2:0]};
    endfunction

    task automatic load(input logic [9:0] w);
        @(negedge clk); mode_load = 1'b1; mode_word = w;
        @(negedge clk); mode_load = 1'b0;
    endtask

    task automatic issue(input bit rd, input int col);
        @(negedge clk); cmd_vld = 1'b1; cmd_rd = rd; start_col = COL_W'(col);
        @(negedge clk); cmd_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic order_check(input bit rd, input int col, input int n,
                               input int exp [8], input string req);
        @(negedge clk); cmd_vld = 1'b1; cmd_rd = rd; start_col = COL_W'(col);
        @(negedge clk); cmd_vld = 1'b0;
        for (int i = 0; i < n; i++) begin
            chk(beat_vld && int'(beat_col[2:0]) == exp[i], req, int'(beat_col[2:0]), exp[i]);
            if (i < n - 1) @(negedge clk);
        end
        idle(6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!beat_vld && !dq_drive && !rd_valid && !mode_err, "R1 reset idle",
            int'({beat_vld, dq_drive, rd_valid, mode_err}), 0);
        rst = 1'b0;
        idle(2);
        // R1: default 4-beat wrapping, latency 2
        issue(1'b1, 10'h2D6); idle(8);
        // R3: 8 beats wrapping, latency 3
        load(mw(3, 0, 3, 0, 0));
        order_check(1'b1, 10'h3A5, 8, '{5, 6, 7, 0, 1, 2, 3, 4}, "R3 wrap order 8");
        // R4: XOR orders, latency 2
        load(mw(3, 1, 2, 0, 0));
        order_check(1'b1, 10'h155, 8, '{5, 4, 7, 6, 1, 0, 3, 2}, "R4 xor order 8");
        load(mw(2, 1, 2, 0, 0));
        order_check(1'b1, 10'h0AB, 4, '{3, 2, 1, 0, 0, 0, 0, 0}, "R4 xor order 4");
        // BL2 wrapping
        load(mw(1, 0, 3, 0, 0));
        order_check(1'b1, 10'h1F1, 2, '{1, 0, 0, 0, 0, 0, 0, 0}, "R3 wrap order 2");
        // R9: writes full, then single
        load(mw(3, 0, 2, 0, 0));
        issue(1'b0, 10'h0E3); idle(10);
        load(mw(3, 0, 2, 1, 0));
        order_check(1'b0, 10'h0E3, 1, '{3, 0, 0, 0, 0, 0, 0, 0}, "R9 single write");
        chk(!beat_vld, "R9 single write ends", int'(beat_vld), 0);
        issue(1'b1, 10'h0E3); idle(12);
        // R2: illegal loads keep settings
        load(mw(2, 1, 2, 0, 1)); idle(1);
        chk(mode_err, "R2 reserved bits flagged", int'(mode_err), 1);
        load(mw(2, 1, 1, 0, 0));
        load(mw(0, 1, 2, 0, 0));
        issue(1'b1, 10'h3FE); idle(12);
        load(mw(2, 1, 3, 0, 0)); idle(1);
        chk(!mode_err, "R2 legal load clears", int'(mode_err), 0);
        // R10: interruptions mid-burst and mid-tail
        issue(1'b1, 10'h101); idle(1);
        issue(1'b1, 10'h206); idle(5);
        issue(1'b0, 10'h30C); idle(1);
        issue(1'b1, 10'h017); idle(12);
        // R12: same-cycle load and command
        @(negedge clk); cmd_vld = 1'b1; cmd_rd = 1'b1; start_col = 10'h0C6;
        mode_load = 1'b1; mode_word = mw(3, 0, 2, 0, 0);
        @(negedge clk); cmd_vld = 1'b0; mode_load = 1'b0;
        idle(12);
        issue(1'b1, 10'h0C6); idle(14);
        // R11: quiet after completion
        chk(!beat_vld && !dq_drive && !rd_valid, "R11 idle after burst",
            int'({beat_vld, dq_drive, rd_valid}), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule